// File: doc/BRIEF.md
# Eight-Input Nested Priority Interrupt Controller

The block collects up to eight interrupt request lines, remembers which are pending, holds a software-written mask and tracks which requests are being serviced. A fixed priority resolver (line 0 strongest, line 7 weakest) compares the best unmasked pending request with the strongest level in service. It raises the processor interrupt line only when the request outranks everything in service, so a lower request waits until every stronger service routine has ended.

Software programs the block through an 8-bit write port with a one-bit port select. A fixed initialization sequence comes first: a start word, a vector-base word, an optional word for an attached controller (accepted and discarded), and an optional mode word. Later writes set the mask, end interrupts (either the strongest in service or a named level), or choose which register a read returns. The processor acknowledges with two strobes. The first strobe moves the winning request into service. The second strobe returns an 8-bit vector for one cycle. Only single-controller operation is supported.

Top module: `prio_intc`

## Requirements
- R1: A write with `wr_a0`=0 and data bit 4 set is the start word. The next `wr_a0`=1 write is the vector-base word. One further `wr_a0`=1 write is skipped when start-word bit 1 was 0, and one mode word is taken when start-word bit 0 was 1. After that, `wr_a0`=1 writes load the mask. `int_out` stays low until the sequence is complete.
- R2: The start word clears the pending, in-service and mask registers, the auto-end flag and the read select (pending is selected). It also drops `int_out` on the next cycle.
- R3: With start-word bit 3 at 0, a pending bit is set by a rising edge of its line and stays set until acknowledged. With it at 1, the pending bits follow the line levels.
- R4: A mask bit at 1 keeps its request from raising `int_out`. Clearing the mask bit lets a held request through. The mask reads back on `rd_data` when `rd_a0`=1.
- R5: Priority is fixed, with line 0 highest. `int_out` rises two cycles after an unmasked request becomes pending, provided it outranks every in-service bit.
- R6: The first `inta` strobe sets the in-service bit of the winning request and clears its pending bit. `int_out` is low on the following cycle.
- R7: In the cycle after the second `inta` strobe, `vec_valid` is 1 for one cycle. `vec_out` then holds vector-base bits 7:3 above the 3-bit level.
- R8: A write with `wr_a0`=0, bit 4=0 and bit 3=0 is an end command. Bits 7:5 = 001 clear the strongest set in-service bit. Bits 7:5 = 011 clear the in-service bit named by bits 2:0.
- R9: A write with `wr_a0`=0, bit 4=0 and bit 3=1 with bit 1 set chooses the `rd_a0`=0 read source: bit 0 = 0 selects pending, 1 selects in-service. `rd_data` is registered one cycle after `rd_a0`.
- R10: With mode-word bit 1 set, the in-service bit is cleared by the second `inta` strobe.
- R11: A pending request that does not outrank the strongest in-service level raises no interrupt. It is served only after every stronger in-service bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command write strobe |
| wr_a0 | input | 1 | Command port select |
| wr_data | input | 8 | Command data |
| rd_a0 | input | 1 | Read select: 1 mask, 0 pending or in-service |
| rd_data | output | 8 | Registered read data |
| irq | input | 8 | Interrupt request lines |
| inta | input | 1 | Acknowledge strobe, one cycle per pulse |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector present on `vec_out` |
| vec_out | output | 8 | Interrupt vector |

## Verification
Two lines raised together check that the lower number wins and that the loser stays pending. A stronger line raised during service checks pre-emption, and a weaker one checks that nothing is raised. A non-specific end followed by a specific end separates the two clearing rules, because only the strongest in-service bit may go. A line held high across acknowledge and end shows edge capture apart from level capture. Runs with and without the optional words check each path through the initialization sequence.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int DATA_W = 8;
  localparam int N_REQ  = 8;
  typedef enum logic [2:0] {
    ST_IDLE, ST_TYPE, ST_SLAVE, ST_MODE, ST_RUN
  } init_st_e;
endpackage

// File: rtl/pic_cmd.sv
module pic_cmd #(
  parameter int N  = pic_pkg::N_REQ,
  parameter int DW = pic_pkg::DATA_W,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_a0,
  input  logic [DW-1:0] wr_data,
  output logic          ready,
  output logic          ltim,
  output logic          aeoi,
  output logic          sel_isr,
  output logic [N-1:0]  imr,
  output logic [DW-LW-1:0] base,
  output logic          icw1_wr,
  output logic          ns_eoi,
  output logic          sp_eoi,
  output logic [LW-1:0] eoi_lvl
);
  import pic_pkg::*;

  init_st_e st;
  logic need_slave, need_mode, ocw_wr;

  assign ready   = (st == ST_RUN);
  assign icw1_wr = wr_en && !wr_a0 && wr_data[4];
  assign ocw_wr  = wr_en && !wr_a0 && !wr_data[4] && ready;
  assign ns_eoi  = ocw_wr && !wr_data[3] && (wr_data[7:5] == 3'b001);
  assign sp_eoi  = ocw_wr && !wr_data[3] && (wr_data[7:5] == 3'b011);
  assign eoi_lvl = wr_data[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      need_slave <= 1'b0;
      need_mode  <= 1'b0;
      ltim <= 1'b0;
      aeoi <= 1'b0;
      sel_isr <= 1'b0;
      imr  <= '0;
      base <= '0;
    end else if (icw1_wr) begin
      st <= ST_TYPE;
      need_slave <= !wr_data[1];
      need_mode  <= wr_data[0];
      ltim <= wr_data[3];
      aeoi <= 1'b0;
      sel_isr <= 1'b0;
      imr  <= '0;
    end else if (wr_en && wr_a0) begin
      case (st)
        ST_TYPE: begin
          base <= wr_data[DW-1:LW];
          st <= need_slave ? ST_SLAVE : (need_mode ? ST_MODE : ST_RUN);
        end
        ST_SLAVE: st <= need_mode ? ST_MODE : ST_RUN;
        ST_MODE: begin
          aeoi <= wr_data[1];
          st <= ST_RUN;
        end
        ST_RUN:  imr <= wr_data[N-1:0];
        default: ;
      endcase
    end else if (ocw_wr && wr_data[3] && wr_data[1]) begin
      sel_isr <= wr_data[0];
    end
  end

  // R4
  imr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(imr));
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int N = pic_pkg::N_REQ
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_all,
  input  logic         ltim,
  input  logic [N-1:0] irq,
  input  logic [N-1:0] ack_clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      irr  <= '0;
      prev <= '0;
    end else begin
      prev <= irq;
      if (clear_all) irr <= '0;
      else irr <= (ltim ? irq : (irr | (irq & ~prev))) & ~ack_clr;
    end
  end

  // R3
  edge_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ltim && !clear_all && ack_clr == '0) |=> ((irr & $past(irr)) == $past(irr)));
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N = pic_pkg::N_REQ,
  localparam int LW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  imr,
  input  logic [N-1:0]  isr,
  output logic [LW-1:0] win_lvl,
  output logic          win_any,
  output logic [LW-1:0] top_lvl,
  output logic          top_any,
  output logic          elig
);
  logic [N-1:0] pend;
  assign pend = irr & ~imr;

  always_comb begin
    win_any = 1'b0;
    win_lvl = '0;
    top_any = 1'b0;
    top_lvl = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_any = 1'b1;
        win_lvl = LW'(i);
      end
      if (isr[i]) begin
        top_any = 1'b1;
        top_lvl = LW'(i);
      end
    end
    elig = win_any && (!top_any || (win_lvl < top_lvl));
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = pic_pkg::N_REQ,
  parameter int DW = pic_pkg::DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_a0,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_a0,
  output logic [DW-1:0] rd_data,
  input  logic [N-1:0]  irq,
  input  logic          inta,
  output logic          int_out,
  output logic          vec_valid,
  output logic [DW-1:0] vec_out
);
  localparam int LW = $clog2(N);

  logic ready, ltim, aeoi, sel_isr, icw1_wr, ns_eoi, sp_eoi;
  logic [N-1:0] imr, irr, isr, set_mask, clr_mask;
  logic [DW-LW-1:0] base;
  logic [LW-1:0] eoi_lvl, win_lvl, top_lvl, lvl_q;
  logic win_any, top_any, elig, ack2, spur, ack1_hit, ack2_hit;

  pic_cmd #(.N(N), .DW(DW)) u_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_a0(wr_a0), .wr_data(wr_data),
    .ready(ready), .ltim(ltim), .aeoi(aeoi), .sel_isr(sel_isr), .imr(imr),
    .base(base), .icw1_wr(icw1_wr), .ns_eoi(ns_eoi), .sp_eoi(sp_eoi),
    .eoi_lvl(eoi_lvl));

  pic_req #(.N(N)) u_req (
    .clk(clk), .rst(rst), .clear_all(icw1_wr), .ltim(ltim), .irq(irq),
    .ack_clr(set_mask), .irr(irr));

  pic_prio #(.N(N)) u_prio (
    .irr(irr), .imr(imr), .isr(isr), .win_lvl(win_lvl), .win_any(win_any),
    .top_lvl(top_lvl), .top_any(top_any), .elig(elig));

  assign ack1_hit = inta && !ack2;
  assign ack2_hit = inta && ack2;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (ack1_hit && elig) set_mask[win_lvl] = 1'b1;
    if (ns_eoi && top_any) clr_mask[top_lvl] = 1'b1;
    if (sp_eoi) clr_mask[eoi_lvl] = 1'b1;
    if (ack2_hit && aeoi && !spur) clr_mask[lvl_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr <= '0;
      ack2 <= 1'b0;
      lvl_q <= '0;
      spur <= 1'b0;
      int_out <= 1'b0;
      vec_valid <= 1'b0;
      vec_out <= '0;
      rd_data <= '0;
    end else begin
      isr <= icw1_wr ? '0 : ((isr | set_mask) & ~clr_mask);
      if (icw1_wr) ack2 <= 1'b0;
      else if (ack1_hit) ack2 <= 1'b1;
      else if (ack2_hit) ack2 <= 1'b0;
      if (ack1_hit) begin
        lvl_q <= elig ? win_lvl : LW'(N - 1);
        spur <= !elig;
      end
      int_out <= !icw1_wr && ready && elig && !ack2 && !inta;
      vec_valid <= ack2_hit;
      if (ack2_hit) vec_out <= {base, lvl_q};
      rd_data <= rd_a0 ? DW'(imr) : (sel_isr ? DW'(isr) : DW'(irr));
    end
  end

  // R6
  int_drop_chk: assert property (@(posedge clk) disable iff (rst)
    inta |=> !int_out);
  // R6
  isr_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ack1_hit && elig && !ns_eoi && !sp_eoi && !icw1_wr) |=> isr[lvl_q]);
  // R7
  vec_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> $past(inta && ack2));
  // R2
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    icw1_wr |=> (isr == '0) && !int_out);
  // R4
  int_src_chk: assert property (@(posedge clk) disable iff (rst)
    int_out |-> |($past(irr & ~imr)));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, wr_a0 = 1'b0, rd_a0 = 1'b0, inta = 1'b0;
  logic [7:0] wr_data = '0, irq = '0;
  logic [7:0] rd_data, vec_out;
  logic int_out, vec_valid;
  int nchk = 0, nerr = 0;
  bit mon_on = 1'b0, done = 1'b0;

  always #2 clk = ~clk;

  prio_intc u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_a0(wr_a0),
    .wr_data(wr_data), .rd_a0(rd_a0), .rd_data(rd_data), .irq(irq),
    .inta(inta), .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out));

  // behavioural reference model
  int m_st, wl, tl;
  bit m_slave, m_mode, m_ltim, m_aeoi, m_sel, m_ack2, m_spur, m_int, m_vv;
  bit elig, rdy, c1, ocw, ns, sp, a1, a2;
  logic [4:0] m_base;
  logic [2:0] m_lvl;
  logic [7:0] m_imr, m_irr, m_prev, m_isr, m_vec, m_rd, setm, clrm;

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_slave = 0; m_mode = 0; m_ltim = 0; m_aeoi = 0; m_sel = 0;
      m_ack2 = 0; m_spur = 0; m_int = 0; m_vv = 0; m_base = 0; m_lvl = 0;
      m_imr = 0; m_irr = 0; m_prev = 0; m_isr = 0; m_vec = 0; m_rd = 0;
    end else begin
      wl = -1; tl = -1;
      for (int i = 7; i >= 0; i--) begin
        if (m_irr[i] && !m_imr[i]) wl = i;
        if (m_isr[i]) tl = i;
      end
      elig = (wl >= 0) && (tl < 0 || wl < tl);
      rdy = (m_st == 4);
      c1 = wr_en && !wr_a0 && wr_data[4];
      ocw = wr_en && !wr_a0 && !wr_data[4] && rdy;
      ns = ocw && !wr_data[3] && wr_data[7:5] == 3'b001;
      sp = ocw && !wr_data[3] && wr_data[7:5] == 3'b011;
      a1 = inta && !m_ack2;
      a2 = inta && m_ack2;
      setm = 0; clrm = 0;
      if (a1 && elig) setm[wl] = 1'b1;
      if (ns && tl >= 0) clrm[tl] = 1'b1;
      if (sp) clrm[wr_data[2:0]] = 1'b1;
      if (a2 && m_aeoi && !m_spur) clrm[m_lvl] = 1'b1;
      m_int = !c1 && rdy && elig && !m_ack2 && !inta;
      m_rd = rd_a0 ? m_imr : (m_sel ? m_isr : m_irr);
      m_vv = a2;
      if (a2) m_vec = {m_base, m_lvl};
      m_irr = c1 ? 8'h00 : ((m_ltim ? irq : (m_irr | (irq & ~m_prev))) & ~setm);
      m_prev = irq;
      m_isr = c1 ? 8'h00 : ((m_isr | setm) & ~clrm);
      if (a1) begin m_lvl = elig ? 3'(wl) : 3'd7; m_spur = !elig; end
      if (c1) m_ack2 = 0; else if (a1) m_ack2 = 1; else if (a2) m_ack2 = 0;
      if (c1) begin
        m_st = 1; m_slave = !wr_data[1]; m_mode = wr_data[0]; m_ltim = wr_data[3];
        m_aeoi = 0; m_sel = 0; m_imr = 0;
      end else if (wr_en && wr_a0) begin
        case (m_st)
          1: begin m_base = wr_data[7:3]; m_st = m_slave ? 2 : (m_mode ? 3 : 4); end
          2: m_st = m_mode ? 3 : 4;
          3: begin m_aeoi = wr_data[1]; m_st = 4; end
          4: m_imr = wr_data;
          default: ;
        endcase
      end else if (ocw && wr_data[3] && wr_data[1]) m_sel = wr_data[0];
    end
  end

  always @(negedge clk) begin
    if (mon_on && !done) begin
      nchk++;
      if (int_out !== m_int || vec_valid !== m_vv || rd_data !== m_rd ||
          (m_vv && vec_out !== m_vec)) begin
        nerr++;
        $display("FAIL model-compare R5 R7 R9 t=%0t actual int=%b vv=%b vec=%h rd=%h expected int=%b vv=%b vec=%h rd=%h",
          $time, int_out, vec_valid, vec_out, rd_data, m_int, m_vv, m_vec, m_rd);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_a0 = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic a, input logic [7:0] exp);
    rd_a0 = a;
    step(2);
    check(tag, rd_data, exp);
  endtask

  task automatic ack_pair(input logic [7:0] ev);
    inta = 1'b1; @(negedge clk); inta = 1'b0;
    check("R6 int low after first strobe", {7'd0, int_out}, 8'h00);
    @(negedge clk); inta = 1'b1; @(negedge clk); inta = 1'b0;
    check("R7 vec_valid", {7'd0, vec_valid}, 8'h01);
    check("R7 vector", vec_out, ev);
    @(negedge clk);
    check("R7 vec_valid one cycle", {7'd0, vec_valid}, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    mon_on = 1'b1;
    step(1);
    check("R1 reset int", {7'd0, int_out}, 8'h00);
    check("R1 reset rd", rd_data, 8'h00);
    irq = 8'h08; step(4);
    check("R1 no int before init", {7'd0, int_out}, 8'h00);
    irq = 8'h00;
    // single, ICW4 present, edge mode
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h01); wr(1'b1, 8'h00);
    rdchk("R1 mask after init", 1'b1, 8'h00);
    // nested scenario
    irq = 8'h14; step(3);
    check("R5 int on two requests", {7'd0, int_out}, 8'h01);
    ack_pair(8'h42);
    wr(1'b0, 8'h0B); rdchk("R9 isr read", 1'b0, 8'h04);
    wr(1'b0, 8'h0A); rdchk("R11 lower still pending", 1'b0, 8'h10);
    wr(1'b0, 8'h0B);
    irq = 8'h16; step(3);
    check("R5 preempt by line 1", {7'd0, int_out}, 8'h01);
    ack_pair(8'h41);
    rdchk("R11 nested isr", 1'b0, 8'h06);
    irq = 8'h36; step(3);
    check("R11 weaker request held", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h20); rdchk("R8 non-specific end", 1'b0, 8'h04);
    check("R11 line 4 still waits", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h62); rdchk("R8 specific end", 1'b0, 8'h00);
    check("R11 line 4 served", {7'd0, int_out}, 8'h01);
    ack_pair(8'h44);
    wr(1'b0, 8'h20); step(3);
    ack_pair(8'h45);
    wr(1'b0, 8'h20); irq = 8'h00; step(2);
    // mask
    wr(1'b1, 8'h08); rdchk("R4 mask readback", 1'b1, 8'h08);
    irq = 8'h08; step(4);
    check("R4 masked no int", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h00); step(2);
    check("R4 unmask releases", {7'd0, int_out}, 8'h01);
    ack_pair(8'h43);
    wr(1'b0, 8'h20); irq = 8'h00; step(2);
    // edge capture: held line does not retrigger
    irq = 8'h01; step(3);
    ack_pair(8'h40);
    wr(1'b0, 8'h20); step(4);
    check("R3 edge no retrigger", {7'd0, int_out}, 8'h00);
    irq = 8'h00;
    // reinit: level, cascade word, auto end
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h19);
    rdchk("R2 mask cleared", 1'b1, 8'h00);
    check("R2 int low", {7'd0, int_out}, 8'h00);
    wr(1'b1, 8'h88); wr(1'b1, 8'h00); wr(1'b1, 8'h02); wr(1'b1, 8'h00);
    irq = 8'h40; step(3);
    check("R3 level request", {7'd0, int_out}, 8'h01);
    ack_pair(8'h8E);
    wr(1'b0, 8'h0B); rdchk("R10 auto end isr", 1'b0, 8'h00);
    check("R3 level re-raise", {7'd0, int_out}, 8'h01);
    irq = 8'h00; step(3);
    check("R3 level drop", {7'd0, int_out}, 8'h00);
    wr(1'b0, 8'h0A); rdchk("R9 irr read", 1'b0, 8'h00);
    // reinit: single, no mode word
    wr(1'b0, 8'h12); wr(1'b1, 8'h20); wr(1'b1, 8'h01);
    rdchk("R1 third write is mask", 1'b1, 8'h01);
    irq = 8'h03; step(3);
    check("R1 int after short init", {7'd0, int_out}, 8'h01);
    ack_pair(8'h21);
    step(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule